// File: doc/BRIEF.md
# Two-Bank Register File with Cross-Side Access

This block holds the general-purpose registers of a two-sided datapath. There are two banks, side A and side B, each with `NUM_REGS` registers of `DATA_W` bits. By default that is sixteen 32-bit registers per bank, thirty-two in total. Each side drives `PORTS` read ports and `PORTS` write ports. When a port's cross flag is clear, it uses its own side's bank. Every port of a side may touch that bank in the same cycle without restriction.

When a port's cross flag is set, the access goes to the opposite bank through a single shared path. That path carries at most one read and one write per bank per cycle. When several ports of a side compete for the path, the lowest-numbered one is served and the others are refused. A per-bank conflict flag reports the refusal. Reads are combinational. Writes take effect at the rising clock edge. A synchronous reset clears every register.

Top module: `xrf_dual_bank_regfile`

## Requirements
- R1: While `rst` is sampled high at a rising edge, every register of both banks becomes zero, so each later read of any address returns 0.
- R2: An enabled read with cross flag 0 returns, in the same cycle, the current content of its own side's register at `rd_addr`, with `rd_valid` 1. All ports of both sides may do this at once.
- R3: An enabled write with cross flag 0 stores `wr_data` into its own bank at the next rising edge. All ports of a side may write different registers in one cycle. Registers that no accepted write targets keep their value, and a write port with `wr_en` 0 has no effect.
- R4: An enabled read with cross flag 1 on side s reads bank 1-s. At most one such read per bank is served in a cycle: the lowest-numbered requesting port of side s, which gets the data with `rd_valid` 1.
- R5: Cross reads into a bank that lose arbitration return data 0 with `rd_valid` 0. `xrd_conflict[b]` (index b = target bank, 0 = A, 1 = B) is 1 exactly in the cycles when two or more ports request a cross read of bank b.
- R6: Of the cross-flagged writes from side s into bank 1-s, only the lowest-numbered port's write is performed, and the rest have no effect. `xwr_conflict[b]` is 1 exactly in the cycles when two or more ports request a cross write into bank b.
- R7: When several accepted writes target the same register in one cycle, the one with the highest port number wins. The accepted cross write takes part using its own port number. At equal port numbers, the own-side write wins.
- R8: A read port with `rd_en` 0 returns data 0 with `rd_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 2×PORTS | Read enable per side (index 0 = A) and port |
| rd_cross | input | 2×PORTS | Read targets the opposite bank |
| rd_addr | input | 2×PORTS×log2(NUM_REGS) | Read register index |
| rd_data | output | 2×PORTS×DATA_W | Read result, zero when not valid |
| rd_valid | output | 2×PORTS | Read was served this cycle |
| wr_en | input | 2×PORTS | Write enable per side and port |
| wr_cross | input | 2×PORTS | Write targets the opposite bank |
| wr_addr | input | 2×PORTS×log2(NUM_REGS) | Write register index |
| wr_data | input | 2×PORTS×DATA_W | Write value |
| xrd_conflict | output | 2 | Cross-read contention on bank A / B |
| xwr_conflict | output | 2 | Cross-write contention on bank A / B |

## Verification
The bench builds the block with its default parameters: four ports per side, sixteen registers per bank and 32-bit data. This makes four-way contention on the cross path reachable, as well as every port number in the precedence order and both ends of the address range. With these settings, the bench can place lowest-index arbitration, refused reads and dropped writes in the same cycle as full-rate own-side traffic. It can also show how a cross write ranks against own-side writes of lower, equal and higher port number.

// File: rtl/xrf_pkg.sv
package xrf_pkg;

   localparam int SIDES = 2;

   typedef enum logic {
      SIDE_A = 1'b0,
      SIDE_B = 1'b1
   } side_e;

   function automatic int far_side(input int s);
      return (SIDES - 1) - s;
   endfunction

endpackage

// File: rtl/xrf_pick_lowest.sv
module xrf_pick_lowest #(
   parameter  int N  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx,
   output logic          any,
   output logic          clash
);

   if (N < 1) begin : g_bad_n
      $error("xrf_pick_lowest: N must be at least 1");
   end

   always_comb begin
      grant = '0;
      idx   = '0;
      any   = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !any) begin
            grant[i] = 1'b1;
            idx      = IW'(i);
            any      = 1'b1;
         end
      end
   end

   always_comb begin : p_clash
      logic seen;
      seen  = 1'b0;
      clash = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i]) begin
            if (seen) clash = 1'b1;
            seen = 1'b1;
         end
      end
   end

endmodule

// File: rtl/xrf_bank.sv
module xrf_bank #(
   parameter  int PORTS    = 4,
   parameter  int NUM_REGS = 16,
   parameter  int DATA_W   = 32,
   localparam int AW       = $clog2(NUM_REGS),
   localparam int IW       = (PORTS > 1) ? $clog2(PORTS) : 1
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [PORTS-1:0]              own_we,
   input  logic [PORTS-1:0][AW-1:0]      own_waddr,
   input  logic [PORTS-1:0][DATA_W-1:0]  own_wdata,
   input  logic                          x_we,
   input  logic [IW-1:0]                 x_widx,
   input  logic [AW-1:0]                 x_waddr,
   input  logic [DATA_W-1:0]             x_wdata,
   input  logic [PORTS-1:0][AW-1:0]      own_raddr,
   output logic [PORTS-1:0][DATA_W-1:0]  own_rdata,
   input  logic [AW-1:0]                 x_raddr,
   output logic [DATA_W-1:0]             x_rdata
);

   logic [DATA_W-1:0] mem [NUM_REGS];

   // Ascending port order; the later nonblocking assignment wins,
   // and at equal index the own-side write is issued after the cross one.
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int r = 0; r < NUM_REGS; r++) mem[r] <= '0;
      end else begin
         for (int k = 0; k < PORTS; k++) begin
            if (x_we && (x_widx == IW'(k))) mem[x_waddr] <= x_wdata;
            if (own_we[k])                  mem[own_waddr[k]] <= own_wdata[k];
         end
      end
   end

   for (genvar p = 0; p < PORTS; p++) begin : g_rd
      assign own_rdata[p] = mem[own_raddr[p]];
   end
   assign x_rdata = mem[x_raddr];

   logic hit_reg0;
   always_comb begin
      hit_reg0 = x_we && (x_waddr == '0);
      for (int k = 0; k < PORTS; k++)
         if (own_we[k] && (own_waddr[k] == '0)) hit_reg0 = 1'b1;
   end

   AST_TOP_PORT_WRITES: assert property (@(posedge clk) disable iff (rst)
      own_we[PORTS-1] |=> mem[$past(own_waddr[PORTS-1])] == $past(own_wdata[PORTS-1]))
      else $error("top port write lost"); // R7
   AST_REG0_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !hit_reg0 |=> $stable(mem[0]))
      else $error("register 0 changed without a write"); // R3

endmodule

// File: rtl/xrf_dual_bank_regfile.sv
module xrf_dual_bank_regfile
   import xrf_pkg::*;
#(
   parameter  int PORTS    = 4,
   parameter  int NUM_REGS = 16,
   parameter  int DATA_W   = 32,
   localparam int AW       = $clog2(NUM_REGS),
   localparam int IW       = (PORTS > 1) ? $clog2(PORTS) : 1
) (
   input  logic                                   clk,
   input  logic                                   rst,
   input  logic [SIDES-1:0][PORTS-1:0]            rd_en,
   input  logic [SIDES-1:0][PORTS-1:0]            rd_cross,
   input  logic [SIDES-1:0][PORTS-1:0][AW-1:0]    rd_addr,
   output logic [SIDES-1:0][PORTS-1:0][DATA_W-1:0] rd_data,
   output logic [SIDES-1:0][PORTS-1:0]            rd_valid,
   input  logic [SIDES-1:0][PORTS-1:0]            wr_en,
   input  logic [SIDES-1:0][PORTS-1:0]            wr_cross,
   input  logic [SIDES-1:0][PORTS-1:0][AW-1:0]    wr_addr,
   input  logic [SIDES-1:0][PORTS-1:0][DATA_W-1:0] wr_data,
   output logic [SIDES-1:0]                       xrd_conflict,
   output logic [SIDES-1:0]                       xwr_conflict
);

   if (NUM_REGS < 2 || (1 << AW) != NUM_REGS) begin : g_bad_regs
      $error("NUM_REGS must be a power of two, at least 2");
   end
   if (PORTS < 1) begin : g_bad_ports
      $error("PORTS must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end

   // All per-bank arrays are indexed by the target bank.
   logic [SIDES-1:0][PORTS-1:0]             xrd_grant;
   logic [SIDES-1:0][IW-1:0]                xrd_idx;
   logic [SIDES-1:0][DATA_W-1:0]            x_rdata;
   logic [SIDES-1:0][PORTS-1:0][DATA_W-1:0] own_rdata;

   for (genvar b = 0; b < SIDES; b++) begin : g_bank
      localparam int OS = far_side(b);

      logic [PORTS-1:0] xwr_grant;
      logic [IW-1:0]    xwr_idx;
      logic             xwr_any;
      logic             xrd_any;

      xrf_pick_lowest #(.N(PORTS)) u_rd_arb (
         .req   (rd_en[OS] & rd_cross[OS]),
         .grant (xrd_grant[b]),
         .idx   (xrd_idx[b]),
         .any   (xrd_any),
         .clash (xrd_conflict[b])
      );

      xrf_pick_lowest #(.N(PORTS)) u_wr_arb (
         .req   (wr_en[OS] & wr_cross[OS]),
         .grant (xwr_grant),
         .idx   (xwr_idx),
         .any   (xwr_any),
         .clash (xwr_conflict[b])
      );

      xrf_bank #(.PORTS(PORTS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
         .clk       (clk),
         .rst       (rst),
         .own_we    (wr_en[b] & ~wr_cross[b]),
         .own_waddr (wr_addr[b]),
         .own_wdata (wr_data[b]),
         .x_we      (xwr_any),
         .x_widx    (xwr_idx),
         .x_waddr   (wr_addr[OS][xwr_idx]),
         .x_wdata   (wr_data[OS][xwr_idx]),
         .own_raddr (rd_addr[b]),
         .own_rdata (own_rdata[b]),
         .x_raddr   (rd_addr[OS][xrd_idx[b]]),
         .x_rdata   (x_rdata[b])
      );

      AST_XRD_CONFLICT_REAL: assert property (@(posedge clk) disable iff (rst)
         xrd_conflict[b] |-> ($countones(rd_en[OS] & rd_cross[OS]) > 1))
         else $error("cross-read conflict without contention"); // R5
      AST_XRD_SINGLE: assert property (@(posedge clk) disable iff (rst)
         $countones(rd_valid[OS] & rd_cross[OS]) <= 1)
         else $error("more than one cross read served"); // R4
      AST_XWR_CONFLICT_REAL: assert property (@(posedge clk) disable iff (rst)
         xwr_conflict[b] |-> ($countones(wr_en[OS] & wr_cross[OS]) > 1))
         else $error("cross-write conflict without contention"); // R6
   end

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      localparam int OS = far_side(s);
      for (genvar p = 0; p < PORTS; p++) begin : g_port
         always_comb begin
            if (!rd_en[s][p]) begin
               rd_valid[s][p] = 1'b0;
               rd_data[s][p]  = '0;
            end else if (!rd_cross[s][p]) begin
               rd_valid[s][p] = 1'b1;
               rd_data[s][p]  = own_rdata[s][p];
            end else if (xrd_grant[OS][p]) begin
               rd_valid[s][p] = 1'b1;
               rd_data[s][p]  = x_rdata[OS];
            end else begin
               rd_valid[s][p] = 1'b0;
               rd_data[s][p]  = '0;
            end
         end

         AST_IDLE_PORT_QUIET: assert property (@(posedge clk) disable iff (rst)
            !rd_en[s][p] |-> (!rd_valid[s][p] && rd_data[s][p] == '0))
            else $error("disabled read port active"); // R8
      end
   end

endmodule

// File: tb/xrf_dual_bank_regfile_tb.sv
`timescale 1ns/1ps
module xrf_dual_bank_regfile_tb;

   localparam int P  = 4;
   localparam int NR = 16;
   localparam int DW = 32;
   localparam int AW = $clog2(NR);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [1:0][P-1:0]          rd_en, rd_cross, rd_valid;
   logic [1:0][P-1:0][AW-1:0]  rd_addr;
   logic [1:0][P-1:0][DW-1:0]  rd_data;
   logic [1:0][P-1:0]          wr_en, wr_cross;
   logic [1:0][P-1:0][AW-1:0]  wr_addr;
   logic [1:0][P-1:0][DW-1:0]  wr_data;
   logic [1:0]                 xrd_conflict, xwr_conflict;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   xrf_dual_bank_regfile #(.PORTS(P), .NUM_REGS(NR), .DATA_W(DW)) u_dut (
      .clk(clk), .rst(rst),
      .rd_en(rd_en), .rd_cross(rd_cross), .rd_addr(rd_addr),
      .rd_data(rd_data), .rd_valid(rd_valid),
      .wr_en(wr_en), .wr_cross(wr_cross), .wr_addr(wr_addr), .wr_data(wr_data),
      .xrd_conflict(xrd_conflict), .xwr_conflict(xwr_conflict)
   );

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      rd_en = '0; rd_cross = '0; rd_addr = '0;
      wr_en = '0; wr_cross = '0; wr_addr = '0; wr_data = '0;
   endtask

   // Own-side read through port 0 of side s, sampled mid-cycle.
   task automatic peek(input int s, input int a, output logic [DW-1:0] v);
      @(negedge clk);
      idle();
      rd_en[s][0] = 1'b1;
      rd_addr[s][0] = AW'(a);
      #1 v = rd_data[s][0];
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      @(negedge clk); idle();
      wr_en[0][0] = 1; wr_addr[0][0] = 4'd15; wr_data[0][0] = 32'hDEAD_0001;
      wr_en[1][3] = 1; wr_addr[1][3] = 4'd0;  wr_data[1][3] = 32'hDEAD_0002;
      @(negedge clk); idle(); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      for (int s = 0; s < 2; s++)
         for (int a = 0; a < NR; a++) begin
            peek(s, a, v);
            chk(v == '0, "R1 reset clears", v, '0);
         end
   endtask

   task automatic t_same_side();
      logic [DW-1:0] v;
      @(negedge clk); idle();
      for (int p = 0; p < P; p++) begin
         wr_en[0][p] = 1; wr_addr[0][p] = AW'(p + 1); wr_data[0][p] = 32'hA000_0000 + p;
         wr_en[1][p] = 1; wr_addr[1][p] = AW'(p + 1); wr_data[1][p] = 32'hB000_0000 + p;
      end
      wr_addr[0][0] = 4'd0;            // lowest address
      wr_addr[1][3] = 4'd15;           // highest address
      @(negedge clk); idle();
      wr_en[0][1] = 0; wr_addr[0][1] = 4'd5; wr_data[0][1] = 32'h5555_5555; // disabled
      for (int p = 0; p < P; p++) begin
         rd_en[0][p] = 1; rd_addr[0][p] = AW'(p + 1);
         rd_en[1][p] = 1; rd_addr[1][p] = AW'(p + 1);
      end
      rd_addr[0][0] = 4'd0; rd_addr[1][3] = 4'd15;
      #1;
      for (int s = 0; s < 2; s++)
         for (int p = 0; p < P; p++) begin
            logic [DW-1:0] e;
            e = (s == 0 ? 32'hA000_0000 : 32'hB000_0000) + p;
            chk(rd_valid[s][p] == 1'b1, "R2 own read valid", {31'b0, rd_valid[s][p]}, 1);
            chk(rd_data[s][p] == e, "R2 R3 own write/read", rd_data[s][p], e);
         end
      peek(0, 5, v);
      chk(v == '0, "R3 disabled write and untouched register", v, '0);
   endtask

   task automatic t_cross_read();
      @(negedge clk); idle();
      rd_en[0][2] = 1; rd_cross[0][2] = 1; rd_addr[0][2] = 4'd3;
      rd_en[1][0] = 1; rd_cross[1][0] = 1; rd_addr[1][0] = 4'd2;
      #1;
      chk(rd_valid[0][2] && rd_data[0][2] == 32'hB000_0002, "R4 A reads B", rd_data[0][2], 32'hB000_0002);
      chk(rd_valid[1][0] && rd_data[1][0] == 32'hA000_0001, "R4 B reads A", rd_data[1][0], 32'hA000_0001);
      chk(xrd_conflict == 2'b00, "R5 no conflict on single request", {30'b0, xrd_conflict}, 0);
   endtask

   task automatic t_cross_conflict();
      @(negedge clk); idle();
      rd_en[0][1] = 1; rd_cross[0][1] = 1; rd_addr[0][1] = 4'd1;
      rd_en[0][3] = 1; rd_cross[0][3] = 1; rd_addr[0][3] = 4'd2;
      for (int p = 0; p < P; p++) begin
         rd_en[1][p] = 1; rd_addr[1][p] = AW'(p + 1);
      end
      rd_addr[1][3] = 4'd15;
      #1;
      chk(rd_valid[0][1] && rd_data[0][1] == 32'hB000_0000, "R4 lowest cross reader wins", rd_data[0][1], 32'hB000_0000);
      chk(!rd_valid[0][3] && rd_data[0][3] == '0, "R5 loser refused", rd_data[0][3], '0);
      chk(xrd_conflict == 2'b10, "R5 conflict on bank B only", {30'b0, xrd_conflict}, 2);
      chk(rd_valid[1] == 4'hF && rd_data[1][3] == 32'hB000_0003, "R2 own reads unaffected", rd_data[1][3], 32'hB000_0003);
      @(negedge clk); idle();
      rd_en[0][3] = 1; rd_cross[0][3] = 1; rd_addr[0][3] = 4'd2;
      #1;
      chk(xrd_conflict == 2'b00, "R5 conflict clears", {30'b0, xrd_conflict}, 0);
      chk(rd_valid[0][3] && rd_data[0][3] == 32'hB000_0001, "R4 lone port served", rd_data[0][3], 32'hB000_0001);
   endtask

   task automatic t_cross_write();
      logic [DW-1:0] v;
      @(negedge clk); idle();
      wr_en[1][0] = 1; wr_cross[1][0] = 1; wr_addr[1][0] = 4'd7; wr_data[1][0] = 32'hC0C0_0007;
      wr_en[1][2] = 1; wr_cross[1][2] = 1; wr_addr[1][2] = 4'd8; wr_data[1][2] = 32'hC0C0_0008;
      #1;
      chk(xwr_conflict == 2'b01, "R6 write conflict on bank A", {30'b0, xwr_conflict}, 1);
      @(negedge clk); idle();
      #1;
      chk(xwr_conflict == 2'b00, "R6 write conflict clears", {30'b0, xwr_conflict}, 0);
      peek(0, 7, v); chk(v == 32'hC0C0_0007, "R6 winning cross write", v, 32'hC0C0_0007);
      peek(0, 8, v); chk(v == '0, "R6 losing cross write dropped", v, '0);
      peek(1, 7, v); chk(v == '0, "R6 cross write not in own bank", v, '0);
   endtask

   task automatic t_precedence();
      logic [DW-1:0] v;
      @(negedge clk); idle();
      wr_en[0][0] = 1; wr_addr[0][0] = 4'd9; wr_data[0][0] = 32'h0000_0900;
      wr_en[0][3] = 1; wr_addr[0][3] = 4'd9; wr_data[0][3] = 32'h0000_0903;
      wr_en[1][1] = 1; wr_cross[1][1] = 1; wr_addr[1][1] = 4'd10; wr_data[1][1] = 32'hB1B1_0010;
      wr_en[0][1] = 1; wr_addr[0][1] = 4'd10; wr_data[0][1] = 32'hA1A1_0010;
      @(negedge clk); idle();
      wr_en[1][2] = 1; wr_cross[1][2] = 1; wr_addr[1][2] = 4'd11; wr_data[1][2] = 32'hB2B2_0011;
      wr_en[0][1] = 1; wr_addr[0][1] = 4'd11; wr_data[0][1] = 32'hA1A1_0011;
      peek(0, 9, v);  chk(v == 32'h0000_0903, "R7 higher own port wins", v, 32'h0000_0903);
      peek(0, 10, v); chk(v == 32'hA1A1_0010, "R7 own wins at equal index", v, 32'hA1A1_0010);
      peek(0, 11, v); chk(v == 32'hB2B2_0011, "R7 higher cross index wins", v, 32'hB2B2_0011);
   endtask

   task automatic t_disabled_read();
      @(negedge clk); idle();
      rd_addr[0][2] = 4'd9; rd_addr[1][1] = 4'd3; rd_cross[1][1] = 1;
      #1;
      chk(!rd_valid[0][2] && rd_data[0][2] == '0, "R8 disabled own read", rd_data[0][2], '0);
      chk(!rd_valid[1][1] && rd_data[1][1] == '0, "R8 disabled cross read", rd_data[1][1], '0);
      chk(xrd_conflict == 2'b00, "R8 disabled read makes no conflict", {30'b0, xrd_conflict}, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      idle();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_same_side();
      t_cross_read();
      t_cross_conflict();
      t_cross_write();
      t_precedence();
      t_disabled_read();
      t_reset();
      finish_run();
   end

   initial begin
      #50000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

endmodule